// File: doc/BRIEF.md
# Debug Port Long-Word Read Sequencer

This block is the command engine behind a debug port. A host talks to it through full-duplex serial transfers of fixed length, and a shifter outside this block presents each transfer as one whole word. In every transfer the host sends a 16-bit command or data word and receives a 17-bit response. Each response belongs to the transfer before it, so a command's result comes back in the transfer after the one that carried the command.

The engine knows one command, a 32-bit memory read. After the opcode, the host sends the upper address half and then the lower address half. The engine then drives a single read on an internal bus-master port, which has request, acknowledge and bus-error signals. While the read is pending, every transfer gets a not-ready answer. When the read completes, the two data halves go out, upper half first. The word received while the lower half is sent is taken as the next opcode. A failed access returns a fixed error status in place of the data. An unknown opcode returns an illegal-command status.

Response encoding: bit 16 is a status flag, where 0 means bits 15:0 carry valid data. Not-ready is 0x10000, illegal-command is 0x1FFFF and bus-error is 0x10001. The read opcode is the parameter `RD_OPCODE`, with a default of 0xC3A5.

Top module: `dbg_rd_seq`

## Requirements
- R1: After reset, the response word is 0x10000 (not-ready) and the bus request is low.
- R2: When the engine waits for a command, an opcode other than `RD_OPCODE` makes the response for the next transfer 0x1FFFF, and the engine keeps waiting for a command.
- R3: The transfers that carry the upper and the lower address halves are both answered with 0x10000.
- R4: In the clock cycle after the transfer carrying the lower address half completes, the bus request is high and the bus address equals {upper half, lower half}.
- R5: Once raised, the bus request stays high with a stable address until acknowledge or bus error is seen, and it is low in the cycle after that.
- R6: Every transfer that completes while the read is pending is answered with 0x10000, and its received word is discarded. This holds even when that word equals `RD_OPCODE`.
- R7: After an acknowledge, the next transfer returns {0, read data[31:16]} and the transfer after that returns {0, read data[15:0]}.
- R8: The word received during the transfer that returns the lower data half is decoded as the next opcode.
- R9: After a bus error, the next transfer returns 0x10001, and the word received in that transfer is decoded as the next opcode.
- R10: The response for the next transfer is in place one clock cycle after a transfer completes. This is well inside the eight-cycle limit.
- R11: If acknowledge and bus error arrive in the same cycle, the acknowledge wins and data is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| xfer_done_i | input | 1 | One-cycle pulse when a serial transfer completes |
| rx_word_i | input | 16 | Word received in the completing transfer |
| tx_word_o | output | 17 | Response to send in the next transfer |
| bus_req_o | output | 1 | Internal bus read request |
| bus_addr_o | output | 32 | Read address, held while the request is high |
| bus_ack_i | input | 1 | Read completed, data valid |
| bus_err_i | input | 1 | Read ended in a bus error |
| bus_rdata_i | input | 32 | Read data, sampled on acknowledge |

## Verification
Random addresses and data, with zero to two transfers during the pending read and random gaps, check that each data half lands in the right transfer. The extreme values all-zeros and all-ones are also used for addresses and data. Random words sent while the read is pending, including the read opcode itself, show that the engine really discards them and does not decode them. The word that follows the result is sometimes the read opcode and sometimes an illegal value, which shows whether the lower-data transfer, or the error-status transfer, carries the next opcode. The bus outcome is drawn as plain acknowledge, plain error, or both at once, which separates the error path from the acknowledge-priority rule. An opcode one below the read code checks that the decoder compares the full opcode.

// File: rtl/dbg_rd_pkg.sv
package dbg_rd_pkg;

    // Sequencer phase: what the next completed transfer carries
    typedef enum logic [2:0] {
        PH_CMD,   // opcode expected
        PH_AHI,   // upper address half expected
        PH_ALO,   // lower address half expected
        PH_BUS,   // internal read pending
        PH_RHI    // upper result half being returned
    } phase_e;

    // Kind of response presented for the next transfer
    typedef enum logic [1:0] {
        RK_NOTRDY,
        RK_ILLEGAL,
        RK_BUSERR,
        RK_DATA
    } rkind_e;

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode #(
    parameter int              WORD_W    = 16,
    parameter logic [WORD_W-1:0] RD_OPCODE = 16'hC3A5
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              is_read_o
);

    // full-width compare; any other word is illegal
    always_comb begin
        is_read_o = (word_i == RD_OPCODE);
    end

endmodule

// File: rtl/dbg_resp_fmt.sv
module dbg_resp_fmt
    import dbg_rd_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int RESP_W = WORD_W + 1
) (
    input  rkind_e             kind_i,
    input  logic [WORD_W-1:0]  data_i,
    output logic [RESP_W-1:0]  resp_o
);

    localparam logic [WORD_W-1:0] ALL_ONES = {WORD_W{1'b1}};
    localparam logic [WORD_W-1:0] ONE_LSB  = {{(WORD_W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (kind_i)
            RK_DATA:    resp_o = {1'b0, data_i};
            RK_ILLEGAL: resp_o = {1'b1, ALL_ONES};
            RK_BUSERR:  resp_o = {1'b1, ONE_LSB};
            default:    resp_o = {1'b1, {WORD_W{1'b0}}};
        endcase
    end

endmodule

// File: rtl/dbg_bus_master.sv
module dbg_bus_master #(
    parameter int ADDR_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              bus_ack_i,
    input  logic              bus_err_i,
    output logic              bus_req_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              done_o,
    output logic              fail_o
);

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] addr;
    } bm_state_t;

    bm_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.addr = addr_i;
            end
        end else if (bus_ack_i || bus_err_i) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_req_o  = st_q.busy;
    assign bus_addr_o = st_q.addr;
    // acknowledge takes precedence over error
    assign done_o     = st_q.busy && bus_ack_i;
    assign fail_o     = st_q.busy && bus_err_i && !bus_ack_i;

    // R5
    hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o && !bus_ack_i && !bus_err_i |=> bus_req_o && $stable(bus_addr_o));

    // R5
    drop_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o && (bus_ack_i || bus_err_i) |=> !bus_req_o);

endmodule

// File: rtl/dbg_rd_seq.sv
module dbg_rd_seq
    import dbg_rd_pkg::*;
#(
    parameter int                WORD_W    = 16,
    parameter logic [WORD_W-1:0] RD_OPCODE = 16'hC3A5,
    localparam int               RESP_W    = WORD_W + 1,
    localparam int               ADDR_W    = 2 * WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              xfer_done_i,
    input  logic [WORD_W-1:0] rx_word_i,
    output logic [RESP_W-1:0] tx_word_o,
    output logic              bus_req_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    input  logic              bus_ack_i,
    input  logic              bus_err_i,
    input  logic [ADDR_W-1:0] bus_rdata_i
);

    localparam logic [RESP_W-1:0] RESP_NR  = {1'b1, {WORD_W{1'b0}}};
    localparam logic [RESP_W-1:0] RESP_ILL = {1'b1, {WORD_W{1'b1}}};
    localparam logic [RESP_W-1:0] RESP_ERR = {1'b1, {(WORD_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        phase_e            phase;
        rkind_e            kind;
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] addr_hi;
        logic [WORD_W-1:0] res_lo;
    } seq_state_t;

    seq_state_t st_q, st_d;
    logic       start_d;
    logic       is_read;
    logic       bm_done;
    logic       bm_fail;

    dbg_cmd_decode #(
        .WORD_W    (WORD_W),
        .RD_OPCODE (RD_OPCODE)
    ) i_decode (
        .word_i    (rx_word_i),
        .is_read_o (is_read)
    );

    dbg_bus_master #(
        .ADDR_W (ADDR_W)
    ) i_bus_master (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_d),
        .addr_i     ({st_q.addr_hi, rx_word_i}),
        .bus_ack_i  (bus_ack_i),
        .bus_err_i  (bus_err_i),
        .bus_req_o  (bus_req_o),
        .bus_addr_o (bus_addr_o),
        .done_o     (bm_done),
        .fail_o     (bm_fail)
    );

    dbg_resp_fmt #(
        .WORD_W (WORD_W)
    ) i_fmt (
        .kind_i (st_q.kind),
        .data_i (st_q.data),
        .resp_o (tx_word_o)
    );

    always_comb begin
        st_d    = st_q;
        start_d = 1'b0;
        unique case (st_q.phase)
            PH_CMD: begin
                if (xfer_done_i) begin
                    if (is_read) begin
                        st_d.kind  = RK_NOTRDY;
                        st_d.phase = PH_AHI;
                    end else begin
                        st_d.kind  = RK_ILLEGAL;
                    end
                end
            end
            PH_AHI: begin
                if (xfer_done_i) begin
                    st_d.addr_hi = rx_word_i;
                    st_d.kind    = RK_NOTRDY;
                    st_d.phase   = PH_ALO;
                end
            end
            PH_ALO: begin
                if (xfer_done_i) begin
                    start_d    = 1'b1;
                    st_d.kind  = RK_NOTRDY;
                    st_d.phase = PH_BUS;
                end
            end
            PH_BUS: begin
                // transfers here keep the not-ready answer; their word is dropped
                if (bm_done) begin
                    st_d.kind   = RK_DATA;
                    st_d.data   = bus_rdata_i[ADDR_W-1:WORD_W];
                    st_d.res_lo = bus_rdata_i[WORD_W-1:0];
                    st_d.phase  = PH_RHI;
                end else if (bm_fail) begin
                    st_d.kind  = RK_BUSERR;
                    st_d.phase = PH_CMD;
                end
            end
            PH_RHI: begin
                if (xfer_done_i) begin
                    st_d.kind  = RK_DATA;
                    st_d.data  = st_q.res_lo;
                    st_d.phase = PH_CMD;
                end
            end
            default: begin
                st_d.phase = PH_CMD;
                st_d.kind  = RK_NOTRDY;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase   <= PH_CMD;
            st_q.kind    <= RK_NOTRDY;
            st_q.data    <= '0;
            st_q.addr_hi <= '0;
            st_q.res_lo  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bus_req_o) |-> $past(xfer_done_i) && $past(st_q.phase == PH_ALO));

    // R6
    busy_notrdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o |-> tx_word_o == RESP_NR);

    // R7
    result_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o && bus_ack_i |=> tx_word_o == {1'b0, $past(bus_rdata_i[ADDR_W-1:WORD_W])});

    // R9
    berr_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o && bus_err_i && !bus_ack_i |=> tx_word_o == RESP_ERR);

    // R2
    illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_done_i && st_q.phase == PH_CMD && rx_word_i != RD_OPCODE
        |=> tx_word_o == RESP_ILL && st_q.phase == PH_CMD);

endmodule

// File: tb/test_dbg_rd_seq.sv
module test_dbg_rd_seq;

    localparam logic [15:0] OP   = 16'hC3A5;
    localparam logic [16:0] NR   = 17'h10000;
    localparam logic [16:0] ILL  = 17'h1FFFF;
    localparam logic [16:0] BERR = 17'h10001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_done = 1'b0;
    logic [15:0] rx_word = '0;
    logic [16:0] tx_word;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    int total = 0;
    int bad   = 0;
    logic [16:0] exp_pend;

    always #4 clk = ~clk;

    dbg_rd_seq i_dbg_rd_seq (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .xfer_done_i (xfer_done),
        .rx_word_i   (rx_word),
        .tx_word_o   (tx_word),
        .bus_req_o   (bus_req),
        .bus_addr_o  (bus_addr),
        .bus_ack_i   (bus_ack),
        .bus_err_i   (bus_err),
        .bus_rdata_i (bus_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rand_illegal();
        logic [15:0] w = 16'($urandom);
        while (w == OP) w = 16'($urandom);
        return w;
    endfunction

    function automatic logic [16:0] pend_after(input logic [15:0] op);
        return (op == OP) ? NR : ILL;
    endfunction

    // one transfer: returns the response that went out in it (R10: one-cycle update)
    task automatic xfer(input logic [15:0] w, output logic [16:0] resp);
        resp      = tx_word;
        xfer_done = 1'b1;
        rx_word   = w;
        @(negedge clk);
        xfer_done = 1'b0;
        repeat ($urandom_range(0, 3)) @(negedge clk);
    endtask

    task automatic do_read(input bit skip_op, input logic [31:0] addr, input logic [31:0] data,
                           input bit berr, input bit both, input int nbusy,
                           input logic [15:0] next_op);
        logic [16:0] r;
        if (!skip_op) begin
            xfer(OP, r);
            check("R2/R8 pending response before opcode", 32'(r), 32'(exp_pend));
        end
        xfer(addr[31:16], r);
        check("R3 addr-hi transfer", 32'(r), 32'(skip_op ? exp_pend : NR));
        xfer(addr[15:0], r);
        check("R3 addr-lo transfer", 32'(r), 32'(NR));
        check("R4 request raised", 32'(bus_req), 32'd1);
        check("R4 address", bus_addr, addr);
        for (int i = 0; i < nbusy; i++) begin
            xfer((i == 0) ? OP : 16'($urandom), r);
            check("R6 busy transfer", 32'(r), 32'(NR));
            check("R5 request held", 32'(bus_req), 32'd1);
            check("R5 address stable", bus_addr, addr);
        end
        bus_ack   = !berr || both;
        bus_err   = berr;
        bus_rdata = data;
        @(negedge clk);
        bus_ack = 1'b0;
        bus_err = 1'b0;
        bus_rdata = 32'($urandom);
        check("R5 request dropped", 32'(bus_req), 32'd0);
        if (berr && !both) begin
            xfer(next_op, r);
            check("R9 error status", 32'(r), 32'(BERR));
        end else begin
            xfer(16'($urandom), r);
            check(both ? "R11 ack wins, hi half" : "R7 hi half", 32'(r), {15'd0, 1'b0, data[31:16]});
            xfer(next_op, r);
            check(both ? "R11 ack wins, lo half" : "R7 lo half", 32'(r), {15'd0, 1'b0, data[15:0]});
        end
        exp_pend = pend_after(next_op);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [16:0] r;
        bit          skip;
        logic [15:0] nop;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check("R1 reset response", 32'(tx_word), 32'(NR));
        check("R1 reset request", 32'(bus_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 response after reset release", 32'(tx_word), 32'(NR));

        // illegal opcodes, including one just below the read code
        xfer(OP - 16'd1, r);
        check("R1 first response", 32'(r), 32'(NR));
        xfer(rand_illegal(), r);
        check("R2 illegal response", 32'(r), 32'(ILL));
        xfer(16'hFFFF, r);
        check("R2 still waiting for command", 32'(r), 32'(ILL));
        exp_pend = ILL;

        // directed corners
        do_read(1'b0, 32'h0000_0000, 32'hFFFF_0000, 1'b0, 1'b0, 0, OP);
        do_read(1'b1, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 1'b0, 2, rand_illegal());
        do_read(1'b0, 32'h1234_5678, 32'hDEAD_BEEF, 1'b1, 1'b0, 1, OP);
        do_read(1'b1, 32'h8000_0001, 32'hCAFE_F00D, 1'b1, 1'b1, 0, rand_illegal());
        do_read(1'b0, 32'h0F0F_F0F0, 32'h1111_2222, 1'b1, 1'b0, 0, rand_illegal());

        // random mix
        skip = 1'b0;
        for (int n = 0; n < 40; n++) begin
            bit eb = ($urandom_range(0, 3) == 0);
            bit bb = eb && ($urandom_range(0, 1) == 1);
            nop = ($urandom_range(0, 2) == 0) ? OP : rand_illegal();
            do_read(skip, 32'($urandom), 32'($urandom), eb, bb, int'($urandom_range(0, 2)), nop);
            skip = (nop == OP);
        end

        // R8: after the last read the decoded next opcode decides the pending answer
        xfer(rand_illegal(), r);
        check("R8 decoded next opcode", 32'(r), 32'(exp_pend));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule